// File: doc/BRIEF.md
# Fractional baud-rate generator

This block derives the bit-sampling tick of a UART-style serial port from the peripheral clock. A power-of-two prescaler (divide by 1 up to 32) produces a clock enable. An 11-bit down-counting timer counts those enables and, each time it wraps, emits a one-cycle `baud_tick` and reloads itself from a programmable reload value. A 5-bit fraction selection lengthens some periods by one prescaled clock. A phase accumulator spreads these longer periods evenly, so the average period is (reload + 1 + fraction/32) prescaled clocks.

Software reaches the block through a small byte-wide register bus with three locations:

| Address | Write | Read |
|---|---|---|
| 0 | bits 7:5 = reload[2:0], bits 4:0 = fraction | bits 7:5 = live timer[2:0], bits 4:0 = fraction |
| 1 | reload[10:3] | live timer[10:3] |
| 2 | bit 0 = run, bits 3:1 = prescaler select | bit 0 = run, bits 3:1 = prescaler select, bits 7:4 = 0 |

Address 3 reads as zero. The reload value and fraction are meant to be changed only while run is 0. Setting run starts the timer from the programmed reload. Clearing run freezes the timer so that its value can be read back.

The controller is a three-state machine:
- `ST_IDLE`: stopped; the timer holds its value.
- `ST_COUNT`: counting down.
- `ST_EXTRA`: one stretched prescaled clock at the end of a lengthened period.

Transitions:
- start: `ST_IDLE` to `ST_COUNT` when run is 1; the timer loads the reload value.
- stretch: `ST_COUNT` to `ST_EXTRA` when the timer is at zero, an enable arrives and the accumulator carries.
- wrap: `ST_EXTRA` to `ST_COUNT` on the next enable; the timer reloads and a tick is issued.
- stop: `ST_COUNT` or `ST_EXTRA` to `ST_IDLE` when run is 0.

Top module: `frac_baud_gen`

## Requirements
- R1: After reset, addresses 0, 1 and 2 read 0x00, `baud_tick` is 0 and `presc_err` is 0.
- R2: Address 0 reads {timer[2:0], fraction[4:0]}, with the timer in bits 7:5. Address 1 reads timer[10:3]. Writes to address 0 set reload[2:0] from bits 7:5 and the fraction from bits 4:0. Writes to address 1 set reload[10:3].
- R3: Address 2 holds run in bit 0 and the prescaler select in bits 3:1. Bits 7:4 ignore writes and read as 0.
- R4: In the first cycle after run becomes 1, the timer holds the programmed reload value. It then decrements once per prescaled enable.
- R5: With fraction 0, ticks are exactly (reload + 1) × divisor clock cycles apart. The first tick appears 1 + (reload + 1) × divisor cycles after the clock edge that sets run.
- R6: Prescaler select codes 0 to 5 give divisors 1, 2, 4, 8, 16 and 32.
- R7: Select codes 6 and 7 divide by 32 and read back as written. Writing either code sets `presc_err`, which stays set until reset.
- R8: With fraction F, each of any 32 consecutive periods is reload + 1 or reload + 2 prescaled clocks long. Exactly F of them are the longer length.
- R9: Clearing run stops the timer at its current value and suppresses any further tick. Setting run again reloads the timer and restarts with the R5 timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe, one byte per cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| baud_tick | output | 1 | One-cycle tick at each timer wrap |
| presc_err | output | 1 | Sticky flag: a reserved prescaler code was written |

## Verification
The bench builds the block with the default widths: an 11-bit timer, a 5-bit fraction and a 3-bit prescaler select.

Small reload values (3, 9 and 20) with fast divisors keep periods between 4 and 128 cycles. This makes exact tick-to-tick spacing, the 32-period fractional pattern and the frozen value after a stop cheap to observe.

A large reload of 0x5A3 with the /32 divisor leaves the timer still long enough to read every timer bit back through both byte locations, and to see a single decrement.

// File: rtl/fbg_pkg.sv
package fbg_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_COUNT = 2'd1,
        ST_EXTRA = 2'd2
    } fbg_state_e;

    localparam int ADR_LO   = 0;
    localparam int ADR_HI   = 1;
    localparam int ADR_CTRL = 2;

endpackage

// File: rtl/fbg_regs.sv
module fbg_regs #(
    parameter int TIMER_W = 11,
    parameter int FRAC_W  = 5,
    parameter int SEL_W   = 3,
    parameter int ADDR_W  = 2,
    parameter int MAX_SEL = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_wr,
    input  logic [7:0]         bus_wdata,
    input  logic [TIMER_W-1:0] timer_val,
    output logic [7:0]         bus_rdata,
    output logic [TIMER_W-1:0] reload_val,
    output logic [FRAC_W-1:0]  frac_sel,
    output logic [SEL_W-1:0]   presc_sel,
    output logic               run,
    output logic               presc_err
);
    import fbg_pkg::*;

    localparam int LOW_TMR_W = 8 - FRAC_W;
    localparam int HI_W      = TIMER_W - LOW_TMR_W;

    logic [SEL_W-1:0] wr_sel;
    logic             wr_lo;
    logic             wr_hi;
    logic             wr_ctrl;

    assign wr_sel  = bus_wdata[SEL_W:1];
    assign wr_lo   = bus_wr && (bus_addr == ADDR_W'(ADR_LO));
    assign wr_hi   = bus_wr && (bus_addr == ADDR_W'(ADR_HI));
    assign wr_ctrl = bus_wr && (bus_addr == ADDR_W'(ADR_CTRL));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload_val <= '0;
            frac_sel   <= '0;
            presc_sel  <= '0;
            run        <= 1'b0;
            presc_err  <= 1'b0;
        end else begin
            if (wr_lo) begin
                reload_val[LOW_TMR_W-1:0] <= bus_wdata[7:FRAC_W];
                frac_sel                  <= bus_wdata[FRAC_W-1:0];
            end
            if (wr_hi) begin
                reload_val[TIMER_W-1:LOW_TMR_W] <= bus_wdata[HI_W-1:0];
            end
            if (wr_ctrl) begin
                run       <= bus_wdata[0];
                presc_sel <= wr_sel;
                if (int'(wr_sel) > MAX_SEL) begin
                    presc_err <= 1'b1;
                end
            end
        end
    end

    always_comb begin
        bus_rdata = 8'h00;
        if (bus_addr == ADDR_W'(ADR_LO)) begin
            bus_rdata = {timer_val[LOW_TMR_W-1:0], frac_sel};
        end else if (bus_addr == ADDR_W'(ADR_HI)) begin
            bus_rdata = 8'(timer_val[TIMER_W-1:LOW_TMR_W]);
        end else if (bus_addr == ADDR_W'(ADR_CTRL)) begin
            bus_rdata = 8'({presc_sel, run});
        end
    end

endmodule

// File: rtl/fbg_prescaler.sv
module fbg_prescaler #(
    parameter int SEL_W   = 3,
    parameter int MAX_SEL = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic [SEL_W-1:0] sel,
    output logic             presc_en
);
    localparam int PRE_W = (MAX_SEL > 0) ? MAX_SEL : 1;

    logic [PRE_W-1:0] cnt;
    logic [PRE_W-1:0] mask;
    int               eff_sel;

    // Reserved codes above MAX_SEL use the slowest divisor.
    always_comb begin
        eff_sel = (int'(sel) > MAX_SEL) ? MAX_SEL : int'(sel);
    end

    generate
        for (genvar gi = 0; gi < PRE_W; gi++) begin : g_mask
            assign mask[gi] = (gi < eff_sel);
        end
    endgenerate

    assign presc_en = active && (cnt == mask);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!active || presc_en) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/fbg_timer_fsm.sv
module fbg_timer_fsm #(
    parameter int TIMER_W = 11,
    parameter int FRAC_W  = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic               presc_en,
    input  logic [TIMER_W-1:0] reload_val,
    input  logic [FRAC_W-1:0]  frac_sel,
    output logic [TIMER_W-1:0] timer_val,
    output logic               baud_tick,
    output logic               idle
);
    import fbg_pkg::*;

    fbg_state_e        state;
    fbg_state_e        state_nx;
    logic [FRAC_W-1:0] acc;
    logic [FRAC_W-1:0] acc_sum;
    logic              carry;
    logic              at_zero;
    logic              ev_load;
    logic              ev_dec;
    logic              ev_zero;
    logic              ev_wrap;

    assign {carry, acc_sum} = {1'b0, acc} + {1'b0, frac_sel};
    assign at_zero          = (timer_val == '0);
    assign idle             = (state == ST_IDLE);

    assign ev_load = (state == ST_IDLE) && run;
    assign ev_zero = (state == ST_COUNT) && run && presc_en && at_zero;
    assign ev_dec  = (state == ST_COUNT) && run && presc_en && !at_zero;
    assign ev_wrap = (ev_zero && !carry) ||
                     ((state == ST_EXTRA) && run && presc_en);

    // Next-state logic.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (run) state_nx = ST_COUNT;
            end
            ST_COUNT: begin
                if (!run)                  state_nx = ST_IDLE;
                else if (ev_zero && carry) state_nx = ST_EXTRA;
            end
            ST_EXTRA: begin
                if (!run)          state_nx = ST_IDLE;
                else if (presc_en) state_nx = ST_COUNT;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Outputs and datapath.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            timer_val <= '0;
            acc       <= '0;
            baud_tick <= 1'b0;
        end else begin
            baud_tick <= ev_wrap;
            if (ev_load || ev_wrap) begin
                timer_val <= reload_val;
            end else if (ev_dec) begin
                timer_val <= timer_val - 1'b1;
            end
            if (state == ST_IDLE) begin
                acc <= '0;
            end else if (ev_zero) begin
                acc <= acc_sum;
            end
        end
    end

endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen #(
    parameter int TIMER_W = 11,
    parameter int FRAC_W  = 5,
    parameter int SEL_W   = 3,
    parameter int ADDR_W  = 2,
    parameter int MAX_SEL = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              baud_tick,
    output logic              presc_err
);
    logic [TIMER_W-1:0] timer_val;
    logic [TIMER_W-1:0] reload_val;
    logic [FRAC_W-1:0]  frac_sel;
    logic [SEL_W-1:0]   presc_sel;
    logic               ctrl_run;
    logic               presc_en;
    logic               fsm_idle;

    fbg_regs #(
        .TIMER_W(TIMER_W), .FRAC_W(FRAC_W), .SEL_W(SEL_W),
        .ADDR_W(ADDR_W), .MAX_SEL(MAX_SEL)
    ) i_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .timer_val(timer_val), .bus_rdata(bus_rdata),
        .reload_val(reload_val), .frac_sel(frac_sel),
        .presc_sel(presc_sel), .run(ctrl_run), .presc_err(presc_err)
    );

    fbg_prescaler #(
        .SEL_W(SEL_W), .MAX_SEL(MAX_SEL)
    ) i_presc (
        .clk(clk), .rst_n(rst_n),
        .active(!fsm_idle), .sel(presc_sel), .presc_en(presc_en)
    );

    fbg_timer_fsm #(
        .TIMER_W(TIMER_W), .FRAC_W(FRAC_W)
    ) i_fsm (
        .clk(clk), .rst_n(rst_n),
        .run(ctrl_run), .presc_en(presc_en),
        .reload_val(reload_val), .frac_sel(frac_sel),
        .timer_val(timer_val), .baud_tick(baud_tick), .idle(fsm_idle)
    );

endmodule

// File: rtl/fbg_checker.sv
module fbg_checker #(
    parameter int TIMER_W = 11
) (
    input logic               clk,
    input logic               rst_n,
    input logic               baud_tick,
    input logic               presc_err,
    input logic               run,
    input logic               in_idle,
    input logic [TIMER_W-1:0] timer,
    input logic [TIMER_W-1:0] reload,
    input logic               presc_en
);
    // R7: the error flag never clears once set
    a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        presc_err |=> presc_err);

    // R4: a start loads the programmed reload value
    a_r4_start_loads: assert property (@(posedge clk) disable iff (!rst_n)
        (in_idle && run) |=> (timer == $past(reload)));

    // R9: with run clear the timer is frozen
    a_r9_timer_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> $stable(timer));

    // R9: no tick once run has been clear for a full cycle
    a_r9_no_tick_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && $past(!run)) |-> !baud_tick);

    // R5: every tick follows a prescaler enable
    a_r5_tick_after_enable: assert property (@(posedge clk) disable iff (!rst_n)
        baud_tick |-> $past(presc_en));

endmodule

bind frac_baud_gen fbg_checker #(.TIMER_W(TIMER_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .presc_err(presc_err),
    .run(ctrl_run), .in_idle(fsm_idle), .timer(timer_val),
    .reload(reload_val), .presc_en(presc_en)
);

// File: tb/test_frac_baud_gen.sv
module test_frac_baud_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       baud_tick;
    logic       presc_err;

    int cyc = 0;
    int n = 0;
    int tick_t [0:511];
    int errors = 0;
    int checks = 0;

    frac_baud_gen i_frac_baud_gen (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .baud_tick(baud_tick), .presc_err(presc_err)
    );

    always #5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rst_n && baud_tick && n < 512) begin
            tick_t[n] = cyc;
            n = n + 1;
        end
    end

    always @(posedge clk) begin
        if (cyc == 150000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            errors = errors + 1;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input int adr, input int data);
        @(negedge clk);
        bus_addr  = 2'(adr);
        bus_wdata = 8'(data);
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd(input int adr, output int data);
        bus_addr = 2'(adr);
        #1;
        data = int'(bus_rdata);
    endtask

    task automatic start(input int rl, input int sel, input int fd,
                         output int c0, output int b);
        wr(2, 0);
        repeat (2) @(negedge clk);
        wr(0, ((rl & 7) << 5) | (fd & 31));
        wr(1, (rl >> 3) & 255);
        b = n;
        wr(2, ((sel & 7) << 1) | 1);
        c0 = cyc;
    endtask

    task automatic wait_ticks(input int k, input int limit);
        int w = 0;
        while (n < k && w < limit) begin
            @(negedge clk);
            w++;
        end
    endtask

    task automatic t_reset();
        int v;
        rd(0, v); chk("R1 addr0 after reset", v, 0);
        rd(1, v); chk("R1 addr1 after reset", v, 0);
        rd(2, v); chk("R1 addr2 after reset", v, 0);
        chk("R1 tick after reset", int'(baud_tick), 0);
        chk("R1 err after reset", int'(presc_err), 0);
    endtask

    task automatic t_ctrl_bits();
        int v;
        wr(2, 'hF4);
        rd(2, v); chk("R3 upper bits read zero, select kept", v, 'h04);
        wr(2, 0);
        rd(2, v); chk("R3 control cleared", v, 0);
    endtask

    task automatic t_load_readback();
        int c0, b, v;
        start('h5A3, 5, 'h0A, c0, b);
        @(negedge clk);
        rd(0, v); chk("R2 R4 low byte after load", v, 'h6A);
        rd(1, v); chk("R2 R4 high byte after load", v, 'hB4);
        repeat (40) @(negedge clk);
        rd(0, v); chk("R4 one decrement low byte", v, 'h4A);
        rd(1, v); chk("R4 one decrement high byte", v, 'hB4);
        wr(2, 0);
    endtask

    task automatic t_period(input int rl, input int sel, input string req);
        int c0, b;
        int p = (1 << sel);
        start(rl, sel, 0, c0, b);
        wait_ticks(b + 3, 3 * (rl + 1) * p + 100);
        chk({req, " first tick offset"}, tick_t[b] - c0, 1 + (rl + 1) * p);
        chk({req, " spacing 1"}, tick_t[b + 1] - tick_t[b], (rl + 1) * p);
        chk({req, " spacing 2"}, tick_t[b + 2] - tick_t[b + 1], (rl + 1) * p);
        wr(2, 0);
    endtask

    task automatic t_reserved();
        int c0, b, v;
        start(3, 6, 0, c0, b);
        chk("R7 err set by code 6", int'(presc_err), 1);
        rd(2, v); chk("R7 code 6 reads back", v, 'h0D);
        wait_ticks(b + 2, 400);
        chk("R7 code 6 divides by 32", tick_t[b + 1] - tick_t[b], 128);
        wr(2, 'h02);
        chk("R7 err sticky", int'(presc_err), 1);
        wr(2, 0);
    endtask

    task automatic t_fraction(input int fd);
        int c0, b, sum, longs, bad;
        start(3, 0, fd, c0, b);
        wait_ticks(b + 33, 400);
        sum = 0; longs = 0; bad = 0;
        for (int i = 0; i < 32; i++) begin
            int d = tick_t[b + i + 1] - tick_t[b + i];
            sum += d;
            if (d == 5) longs++;
            else if (d != 4) bad++;
        end
        chk("R8 lengths only 4 or 5", bad, 0);
        chk("R8 stretched periods in 32", longs, fd);
        chk("R8 total over 32 periods", sum, 128 + fd);
        wr(2, 0);
    endtask

    task automatic t_stop_restart();
        int c0, b, v, lo, hi, nb, t0;
        start(20, 0, 0, c0, b);
        repeat (5) @(negedge clk);
        wr(2, 0);
        rd(0, lo); rd(1, hi);
        chk("R9 timer frozen value", (hi << 3) | (lo >> 5), 14);
        nb = n;
        repeat (100) @(negedge clk);
        rd(0, lo); rd(1, hi);
        chk("R9 timer held", (hi << 3) | (lo >> 5), 14);
        chk("R9 no ticks while stopped", n, nb);
        b = n;
        wr(2, 1);
        t0 = cyc;
        wait_ticks(b + 1, 200);
        chk("R9 restart first tick", tick_t[b] - t0, 22);
        v = 0;
        wr(2, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ctrl_bits();
        t_load_readback();
        t_period(9, 0, "R5 div1");
        t_period(3, 2, "R6 div4");
        t_period(3, 5, "R6 div32");
        t_period(1, 1, "R6 div2");
        t_reserved();
        t_fraction(5);
        t_fraction(16);
        t_stop_restart();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule